// File: doc/BRIEF.md
# Hinted Write-Through L1 Data Cache

This block is a small two-way set-associative first-level data cache. It sits between a single load/store request port and a next-level memory port. Loads are cached: a miss fetches the whole line from the next level, installs it and returns the requested word. Stores are always written through to the next level. Because of this, the cache never holds data that differs from memory, and it has no dirty state and no write-back path.

Each store carries a two-bit hint that chooses how the first level treats it. The hint can ask the cache to keep the line current, to bypass the cache, or to allocate the line as the first candidate for eviction. A mode input sets how store hits behave. In legacy mode a store hit drops the line. In write-caching mode the cache keeps the written data. Requests are handled one at a time: the request port's ready is low from acceptance until the response.

Top module: `wtL1Cache`

## Requirements
- R1: Every accepted store causes exactly one next-level write carrying the store's word address and data. Its completion pulse (`rspValid`) comes no earlier than the cycle in which that write is accepted. A load never causes a next-level write.
- R2: Legacy mode (`writeCacheMode`=0): a store that hits drops the line, so the next load to that line misses. A store that misses never allocates. This holds for every hint code.
- R3: Write-caching mode (`writeCacheMode`=1), hint 2'b00 (normal) or 2'b11 (system, handled the same as normal): a store hit updates the cached word, and later loads hit and return the new value. A store miss fetches and installs the line after the write-through, so a later load to it hits.
- R4: Hint 2'b01 (next-level-only), in either mode: a store that hits drops the line. A store that misses does not allocate.
- R5: Hint 2'b10 (streaming), in write-caching mode: the store updates or allocates its line and marks it as evict-first.
- R6: A load miss issues one line-aligned next-level read (word offset bits zero). It installs the returned line and returns the requested word in the cycle the line arrives. Later loads to any word of that line hit.
- R7: The victim on allocation is chosen in this order: an invalid way (way 0 first), then an evict-first way (way 0 first), then the least-recently-used way of the set. Hits and fills make the used way most recent.
- R8: A load hit raises `rspValid` with the word in the cycle after acceptance, and issues no next-level request.
- R9: `reqReady` is low from the cycle after acceptance through the response cycle. Exactly one `rspValid` pulse is produced per accepted request.
- R10: Reset clears every valid and evict-first bit, so the first load to any address after reset misses.
- R11: A next-level request held while `memReqReady` is low keeps its valid, direction, address and data unchanged until it is accepted.

Address layout with default parameters: word address bits [1:0] select the word within the line, bits [5:2] select the set, and bits [15:6] are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| writeCacheMode | input | 1 | 1: store hits keep written data; 0: store hits drop the line |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Cache idle and able to accept a request |
| reqWrite | input | 1 | 1 store, 0 load |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Store data |
| reqHint | input | 2 | Store hint: 00 normal, 01 next-level-only, 10 streaming, 11 system |
| rspValid | output | 1 | One-cycle response or completion pulse |
| rspData | output | DATA_W | Load data (zero for store completions) |
| memReqValid | output | 1 | Next-level request present |
| memReqReady | input | 1 | Next level accepts the request |
| memReqWrite | output | 1 | 1 word write, 0 line read |
| memReqAddr | output | ADDR_W | Word address (line-aligned for reads) |
| memReqWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Line read data present |
| memRspLine | input | DATA_W*LINE_WORDS | Returned line, word 0 in the low bits |

## Verification
The bound checker watches the protocol rules on every cycle. These are: ready held low while a request is outstanding, a single response per request, a store completing only after its write has been accepted, no writes during loads, and next-level requests held stable until accepted. Whether a given access hits or misses, which way is evicted, and whether data is stale are matters of cache contents. Only the bench's scenarios can show these, using its behavioural model of tags, evict-first marks and LRU bits. Examples are a streaming line being evicted ahead of the LRU way, legacy and next-level-only invalidation, and allocation on store misses.

// File: rtl/l1c_pkg.sv
package l1c_pkg;

  typedef enum logic [1:0] {
    HINT_NORMAL = 2'b00,
    HINT_NEXT   = 2'b01,
    HINT_STREAM = 2'b10,
    HINT_SYSTEM = 2'b11
  } hint_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOKUP,
    S_MEMWR,
    S_FILLREQ,
    S_FILLWAIT
  } l1State_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch the incoming request
    logic touch;       // make the hit way most recent
    logic invalidate;  // drop the hit way
    logic writeWord;   // merge store data into the hit way
    logic install;     // place the fill line into the victim way
    logic efVal;       // evict-first value for writeWord / install
    logic useFill;     // read word from the fill line
  } l1Strobe_t;

endpackage

// File: rtl/l1cDatapath.sv
module l1cDatapath
  import l1c_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  l1Strobe_t                    strobe,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  input  logic                         reqWrite,
  input  logic [1:0]                   reqHint,
  input  logic [DATA_W*LINE_WORDS-1:0] memRspLine,
  output logic                         qWrite,
  output logic [1:0]                   qHint,
  output logic                         hit,
  output logic [DATA_W-1:0]            rdWord,
  output logic [DATA_W-1:0]            qWdata,
  output logic [ADDR_W-1:0]            wrAddr,
  output logic [ADDR_W-1:0]            fillAddr
);

  localparam int WAYS   = 2;
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;

  logic [ADDR_W-1:0] qAddr;
  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  off;
  logic [TAG_W-1:0]  tagQ;

  logic [TAG_W-1:0]  tagA  [SETS][WAYS];
  logic [LINE_W-1:0] dataA [SETS][WAYS];
  logic [WAYS-1:0]   validA[SETS];
  logic [WAYS-1:0]   efA   [SETS];
  logic [SETS-1:0]   lruA;

  logic [WAYS-1:0]   hitVec;
  logic              hitWay;
  logic              victim;
  logic [LINE_W-1:0] selLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qAddr  <= '0;
      qWdata <= '0;
      qWrite <= 1'b0;
      qHint  <= 2'b00;
    end else if (strobe.capture) begin
      qAddr  <= reqAddr;
      qWdata <= reqWdata;
      qWrite <= reqWrite;
      qHint  <= reqHint;
    end
  end

  assign off  = qAddr[OFF_W-1:0];
  assign idx  = qAddr[OFF_W +: IDX_W];
  assign tagQ = qAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = validA[idx][w] && (tagA[idx][w] == tagQ);
  end

  assign hit    = |hitVec;
  assign hitWay = hitVec[1];

  // invalid first, then evict-first, then LRU
  always_comb begin
    if (!validA[idx][0])      victim = 1'b0;
    else if (!validA[idx][1]) victim = 1'b1;
    else if (efA[idx][0])     victim = 1'b0;
    else if (efA[idx][1])     victim = 1'b1;
    else                      victim = lruA[idx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        validA[s] <= '0;
        efA[s]    <= '0;
      end
      lruA <= '0;
    end else begin
      if (strobe.invalidate && hit) begin
        validA[idx][hitWay] <= 1'b0;
        efA[idx][hitWay]    <= 1'b0;
      end
      if (strobe.writeWord && hit) efA[idx][hitWay] <= strobe.efVal;
      if (strobe.touch && hit)     lruA[idx] <= ~hitWay;
      if (strobe.install) begin
        validA[idx][victim] <= 1'b1;
        efA[idx][victim]    <= strobe.efVal;
        lruA[idx]           <= ~victim;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.writeWord && hit)
      dataA[idx][hitWay][int'(off)*DATA_W +: DATA_W] <= qWdata;
    if (strobe.install) begin
      tagA[idx][victim]  <= tagQ;
      dataA[idx][victim] <= memRspLine;
    end
  end

  assign selLine  = strobe.useFill ? memRspLine : dataA[idx][hitWay];
  assign rdWord   = selLine[int'(off)*DATA_W +: DATA_W];
  assign wrAddr   = qAddr;
  assign fillAddr = {qAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/l1cControl.sv
module l1cControl
  import l1c_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      writeCacheMode,
  input  logic      reqValid,
  input  logic      qWrite,
  input  logic [1:0] qHint,
  input  logic      hit,
  input  logic      memReqReady,
  input  logic      memRspValid,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memReqValid,
  output logic      memReqWrite,
  output l1Strobe_t strobe
);

  l1State_e state, nextState;
  logic needAlloc, allocEf;
  logic allocSet, efSet;
  logic isNext, isStream;

  assign isNext   = (qHint == HINT_NEXT);
  assign isStream = (qHint == HINT_STREAM);

  always_comb begin
    nextState   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    rspValid    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    allocSet    = 1'b0;
    efSet       = 1'b0;
    case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capture = 1'b1;
          nextState      = S_LOOKUP;
        end
      end
      S_LOOKUP: begin
        if (!qWrite) begin
          if (hit) begin
            rspValid     = 1'b1;
            strobe.touch = 1'b1;
            nextState    = S_IDLE;
          end else begin
            nextState = S_FILLREQ;
          end
        end else begin
          nextState = S_MEMWR;
          if (!writeCacheMode || isNext) begin
            strobe.invalidate = 1'b1;
          end else if (hit) begin
            strobe.writeWord = 1'b1;
            strobe.touch     = 1'b1;
            strobe.efVal     = isStream;
          end else begin
            allocSet = 1'b1;
            efSet    = isStream;
          end
        end
      end
      S_MEMWR: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          if (needAlloc) nextState = S_FILLREQ;
          else begin
            rspValid  = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      S_FILLREQ: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_FILLWAIT;
      end
      S_FILLWAIT: begin
        if (memRspValid) begin
          strobe.install = 1'b1;
          strobe.useFill = 1'b1;
          strobe.efVal   = allocEf;
          rspValid       = 1'b1;
          nextState      = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      needAlloc <= 1'b0;
      allocEf   <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_LOOKUP) begin
        needAlloc <= allocSet;
        allocEf   <= efSet;
      end
    end
  end

endmodule

// File: rtl/wtL1Cache.sv
module wtL1Cache
  import l1c_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int SETS       = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         writeCacheMode,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [DATA_W-1:0]            reqWdata,
  input  logic [1:0]                   reqHint,
  output logic                         rspValid,
  output logic [DATA_W-1:0]            rspData,
  output logic                         memReqValid,
  input  logic                         memReqReady,
  output logic                         memReqWrite,
  output logic [ADDR_W-1:0]            memReqAddr,
  output logic [DATA_W-1:0]            memReqWdata,
  input  logic                         memRspValid,
  input  logic [DATA_W*LINE_WORDS-1:0] memRspLine
);

  l1Strobe_t         strobe;
  logic              qWrite;
  logic [1:0]        qHint;
  logic              hit;
  logic [DATA_W-1:0] rdWord;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] fillAddr;

  l1cControl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .writeCacheMode (writeCacheMode),
    .reqValid       (reqValid),
    .qWrite         (qWrite),
    .qHint          (qHint),
    .hit            (hit),
    .memReqReady    (memReqReady),
    .memRspValid    (memRspValid),
    .reqReady       (reqReady),
    .rspValid       (rspValid),
    .memReqValid    (memReqValid),
    .memReqWrite    (memReqWrite),
    .strobe         (strobe)
  );

  l1cDatapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SETS       (SETS),
    .LINE_WORDS (LINE_WORDS)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqWrite   (reqWrite),
    .reqHint    (reqHint),
    .memRspLine (memRspLine),
    .qWrite     (qWrite),
    .qHint      (qHint),
    .hit        (hit),
    .rdWord     (rdWord),
    .qWdata     (memReqWdata),
    .wrAddr     (wrAddr),
    .fillAddr   (fillAddr)
  );

  assign memReqAddr = memReqWrite ? wrAddr : fillAddr;
  assign rspData    = qWrite ? '0 : rdWord;

endmodule

// File: rtl/wtL1CacheChk.sv
module wtL1CacheChk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [DATA_W-1:0] memReqWdata
);

  logic busy, curWrite, wrDone;
  logic wrFire;

  assign wrFire = memReqValid && memReqReady && memReqWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      curWrite <= 1'b0;
      wrDone   <= 1'b0;
    end else if (reqValid && reqReady) begin
      busy     <= 1'b1;
      curWrite <= reqWrite;
      wrDone   <= 1'b0;
    end else begin
      if (wrFire)   wrDone <= 1'b1;
      if (rspValid) busy   <= 1'b0;
    end
  end

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  p_rsp_has_req_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> busy);

  p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_store_after_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && curWrite) |-> (wrDone || wrFire));

  p_load_no_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (busy && curWrite));

  p_one_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrFire |=> !(memReqValid && memReqWrite));

  p_hold_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqWrite) && $stable(memReqAddr) && $stable(memReqWdata)));

endmodule

bind wtL1Cache wtL1CacheChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqWrite    (reqWrite),
  .rspValid    (rspValid),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memReqWdata (memReqWdata)
);

// File: tb/sim_wtL1Cache.sv
module sim_wtL1Cache;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 16;
  localparam int LW     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeCacheMode = 1'b1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [1:0] reqHint = 2'b00;
  logic rspValid;
  logic [DATA_W-1:0] rspData;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic memReqWrite;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqWdata;
  logic memRspValid = 1'b0;
  logic [DATA_W*LW-1:0] memRspLine = '0;

  always #2 clk = ~clk;

  wtL1Cache u0 (.*);

  int nChk = 0;
  int nFail = 0;

  // next-level memory model
  logic [DATA_W-1:0] memStore [int];
  int nReads = 0, nWrites = 0;
  int lastWA = -1;
  logic [DATA_W-1:0] lastWD = '0;
  int rdCnt = 0, rdBase = 0;
  bit stallPrev = 0;
  int stallAddr = 0;

  function automatic logic [DATA_W-1:0] memRd(int a);
    if (memStore.exists(a)) return memStore[a];
    return (a * 32'h0001_0003) ^ 32'hA5A5_0000;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rstN) begin
      rdCnt = 0; memRspValid = 0; stallPrev = 0; memReqReady = 0;
    end else begin
      if (stallPrev) // R11: stalled request unchanged
        chk(memReqValid && (memReqAddr == stallAddr[ADDR_W-1:0]), "R11",
            "held request", memReqAddr, stallAddr);
      memReqReady = ($urandom_range(0, 3) != 0);
      if (memRspValid) memRspValid = 0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          memStore[int'(memReqAddr)] = memReqWdata;
          nWrites++; lastWA = int'(memReqAddr); lastWD = memReqWdata;
        end else begin
          nReads++; rdBase = int'(memReqAddr); rdCnt = 2;
        end
      end else if (rdCnt > 0) begin
        rdCnt--;
        if (rdCnt == 0) begin
          for (int w = 0; w < LW; w++) memRspLine[w*DATA_W +: DATA_W] = memRd(rdBase + w);
          memRspValid = 1;
        end
      end
      stallPrev = memReqValid && !memReqReady;
      stallAddr = int'(memReqAddr);
    end
  end

  // behavioural cache model
  bit mV[SETS][2], mE[SETS][2];
  int mT[SETS][2];
  int mL[SETS];

  task automatic clearModel();
    for (int s = 0; s < SETS; s++) begin
      mV[s][0] = 0; mV[s][1] = 0; mE[s][0] = 0; mE[s][1] = 0; mL[s] = 0;
    end
  endtask

  function automatic int findWay(int a);
    int s = (a >> 2) % SETS;
    for (int w = 0; w < 2; w++) if (mV[s][w] && mT[s][w] == (a >> 6)) return w;
    return -1;
  endfunction

  function automatic int pickVictim(int s);
    if (!mV[s][0]) return 0;
    if (!mV[s][1]) return 1;
    if (mE[s][0]) return 0;
    if (mE[s][1]) return 1;
    return mL[s];
  endfunction

  task automatic install(int a, bit ef);
    int s = (a >> 2) % SETS;
    int v = pickVictim(s);
    mV[s][v] = 1; mT[s][v] = a >> 6; mE[s][v] = ef; mL[s] = 1 - v;
  endtask

  task automatic doReq(bit wr, int a, logic [DATA_W-1:0] d, int hint, string tagOv);
    int s = (a >> 2) % SETS;
    int way = findWay(a);
    bit alloc;
    int expReads, r0, w0, n;
    bit seen, readyBad;
    string tg;
    alloc = wr && writeCacheMode && hint != 1 && way < 0;
    expReads = wr ? int'(alloc) : (way < 0 ? 1 : 0);
    if (tagOv != "") tg = tagOv;
    else if (!wr) tg = (way >= 0) ? "R8" : "R6";
    else if (!writeCacheMode) tg = "R2";
    else if (hint == 1) tg = "R4";
    else if (hint == 2) tg = "R5";
    else tg = "R3";
    @(negedge clk); #1;
    r0 = nReads; w0 = nWrites;
    reqValid = 1; reqWrite = wr; reqAddr = a[ADDR_W-1:0]; reqWdata = d;
    reqHint = hint[1:0];
    chk(reqReady, "R9", "ready when idle", reqReady, 1);
    @(negedge clk); #1;
    reqValid = 0;
    seen = 0; readyBad = 0; n = 0;
    while (!seen && n < 100) begin
      n++;
      if (reqReady) readyBad = 1;
      if (rspValid) seen = 1;
      else begin @(negedge clk); #1; end
    end
    chk(seen, tg, "response seen", seen, 1);
    chk(!readyBad, "R9", "ready low while busy", readyBad, 0);
    if (!seen) return;
    chk(nReads - r0 == expReads, tg, "line reads", nReads - r0, expReads);
    if (!wr) begin
      chk(rspData == memRd(a), tg, "load data", rspData, memRd(a));
      chk(nWrites == w0, "R1", "no write on load", nWrites - w0, 0);
      if (way >= 0) chk(n == 1, "R8", "hit latency", n, 1);
      if (way < 0) chk(rdBase == (a & ~3), "R6", "fill address", rdBase, a & ~3);
    end else begin
      chk(nWrites - w0 == 1, "R1", "write count", nWrites - w0, 1);
      chk(lastWA == a && lastWD == d, "R1", "write addr/data", lastWA, a);
    end
    // model update
    if (!wr) begin
      if (way >= 0) mL[s] = 1 - way; else install(a, 0);
    end else if (!writeCacheMode || hint == 1) begin
      if (way >= 0) begin mV[s][way] = 0; mE[s][way] = 0; end
    end else if (way >= 0) begin
      mE[s][way] = (hint == 2); mL[s] = 1 - way;
    end else install(a, hint == 2);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; reqValid = 0;
    repeat (3) @(negedge clk);
    clearModel();
    rstN = 1;
  endtask

  function automatic int mk(int tag, int set, int off);
    return (tag << 6) | (set << 2) | off;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    clearModel();
    doReset();
    @(negedge clk); #1;
    chk(reqReady && !rspValid && !memReqValid, "R10", "reset outputs",
        {reqReady, rspValid, memReqValid}, 3'b100);
    // R10: first load after reset misses
    doReq(0, mk(1, 1, 0), 0, 0, "R10");
    doReq(0, mk(1, 1, 0), 0, 0, "R8");
    doReq(0, mk(1, 1, 3), 0, 0, "R6");
    // R3: write-caching, normal and system hints
    writeCacheMode = 1;
    doReq(1, mk(1, 1, 2), 32'h1111_2222, 0, "R3");
    doReq(0, mk(1, 1, 2), 0, 0, "R3");
    doReq(1, mk(2, 2, 1), 32'h3333_4444, 3, "R3");
    doReq(0, mk(2, 2, 1), 0, 0, "R3");
    // R2: legacy invalidates on hit, never allocates
    writeCacheMode = 0;
    doReq(1, mk(1, 1, 1), 32'h5555_6666, 0, "R2");
    doReq(0, mk(1, 1, 1), 0, 0, "R2");
    doReq(1, mk(5, 4, 0), 32'h7777_8888, 2, "R2");
    doReq(0, mk(5, 4, 0), 0, 0, "R2");
    // R4: next-level-only hint invalidates and bypasses
    writeCacheMode = 1;
    doReq(1, mk(1, 1, 1), 32'h9999_AAAA, 1, "R4");
    doReq(0, mk(1, 1, 1), 0, 0, "R4");
    doReq(1, mk(6, 6, 0), 32'hBBBB_CCCC, 1, "R4");
    doReq(0, mk(6, 6, 0), 0, 0, "R4");
    // R5 / R7: streaming line is evicted ahead of LRU way
    doReq(0, mk(1, 3, 0), 0, 0, "R6");
    doReq(0, mk(2, 3, 0), 0, 0, "R6");
    doReq(1, mk(3, 3, 0), 32'hDDDD_EEEE, 2, "R5");
    doReq(0, mk(1, 3, 0), 0, 0, "R7");
    doReq(0, mk(2, 3, 0), 0, 0, "R7");
    doReq(0, mk(3, 3, 0), 0, 0, "R7");
    // R10: reset drops contents
    doReset();
    doReq(0, mk(2, 3, 0), 0, 0, "R10");
    // mixed traffic
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 15) == 0) writeCacheMode = ~writeCacheMode;
      doReq($urandom_range(0, 9) < 4, mk($urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3)), $urandom, $urandom_range(0, 3), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule